// File: doc/BRIEF.md
# DMA Transfer Submission Queue

This block is the register-side front end of a single-channel DMA engine. Software fills in a transfer descriptor (flags and two loop lengths) through a 32-bit register port, then submits it by writing 1 to a start register. Each accepted descriptor receives a 5-bit transfer ID and is held in a small first-in first-out queue until the mover takes it. The mover here is a stub. It runs each descriptor for a number of cycles set by its lengths, then reports completion by ID.

Completions show up as bits in a 32-bit done mask indexed by transfer ID. A read of that mask also clears it. Two interrupt causes are kept in a write-1-to-clear pending register, behind a mask: bit 0 means a queue slot was freed, and bit 1 means a completion was newly recorded. A control FSM has three states. OFF (disabled) flushes everything, RUN moves descriptors, and HOLD (paused) freezes the mover but still accepts submissions. The transitions are OFF→RUN, OFF→HOLD, RUN→HOLD, HOLD→RUN, and RUN/HOLD→OFF, all taken on a control write. The mover stub has two states, IDLE and XFER. IDLE→XFER when it pops a descriptor. XFER→IDLE at the end of a non-cyclic descriptor or on a flush. XFER→XFER at the end of a cyclic descriptor.

Top module: `xfer_submit_queue`

## Requirements
- R1: After reset the control register reads 0, the interrupt mask reads 0b11, and pending, next-ID and done all read 0, with `irq` low.
- R2: The start register (0x408) reads 1 while the engine is disabled or the queue holds DEPTH descriptors, and 0 otherwise. A start write at such a time is ignored.
- R3: The ID register (0x404) returns the ID the next accepted submission receives. Each accepted write of 1 to 0x408 advances it by one, wrapping from 31 to 0.
- R4: When a transfer with ID N completes, bit N of the done register (0x428) is set. Transfers complete in submission order.
- R5: A read of the done register returns the mask and clears the bits it returned.
- R6: Pending (0x84) bit 0 is set when the mover takes a descriptor from the queue. Bit 1 is set when a completion sets a done bit that was clear or was being read in that cycle.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R8: The source register (0x88) reads pending AND NOT mask (mask at 0x80, 1 = masked), and `irq` is high exactly when that value is nonzero.
- R9: With control = 0b11 (enable bit 0, pause bit 1), no descriptor leaves the queue and no transfer completes, but submissions are still accepted.
- R10: With control bit 0 clear, the queue and the active transfer are discarded with no done bit set, and start writes do not advance the ID.
- R11: A descriptor submitted with flag bit 0 (cyclic) set repeats indefinitely, setting its done bit after every pass, until the engine is disabled.
- R12: The flags register (0x40C; bit 0 cyclic, bit 1 last segment, bit 2 partial report) reads back its 3 bits. The length registers (0x418 inner, 0x41C outer) read back their low 8 bits, and a transfer lasts (inner+1)*(outer+1) active cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read side effects) |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt, high while any unmasked cause is pending |

## Verification
The bench fills the queue while paused and then submits once more. A design with an off-by-one full flag would accept the fifth descriptor and advance the ID. It walks the ID past 31 using random lengths, where a wrong wrap would report a completion bit that no submission owns. A cyclic descriptor is left unread across a second pass to confirm that no further end-of-transfer interrupt appears, and a design that pulsed it on every pass would re-raise pending bit 1. A paused queue is disabled and re-enabled, and a design that failed to flush would later show done bits for discarded work.

// File: rtl/xsq_pkg.sv
package xsq_pkg;

    localparam int XSQ_LEN_W = 8;
    localparam int XSQ_ID_W  = 5;
    localparam int XSQ_IDS   = 1 << XSQ_ID_W;

    localparam logic [11:0] A_IRQ_MASK = 12'h080;
    localparam logic [11:0] A_IRQ_PEND = 12'h084;
    localparam logic [11:0] A_IRQ_SRC  = 12'h088;
    localparam logic [11:0] A_CTRL     = 12'h400;
    localparam logic [11:0] A_NEXT_ID  = 12'h404;
    localparam logic [11:0] A_START    = 12'h408;
    localparam logic [11:0] A_FLAGS    = 12'h40C;
    localparam logic [11:0] A_INNER    = 12'h418;
    localparam logic [11:0] A_OUTER    = 12'h41C;
    localparam logic [11:0] A_DONE     = 12'h428;

    typedef enum logic [1:0] {
        CS_OFF  = 2'd0,
        CS_RUN  = 2'd1,
        CS_HOLD = 2'd3
    } ctl_state_t;

    typedef enum logic {
        MV_IDLE = 1'b0,
        MV_XFER = 1'b1
    } mv_state_t;

    typedef struct packed {
        logic [XSQ_ID_W-1:0]  id;
        logic                 cyclic;
        logic [XSQ_LEN_W-1:0] inner;
        logic [XSQ_LEN_W-1:0] outer;
    } xsq_desc_t;

endpackage

// File: rtl/xsq_desc_fifo.sv
module xsq_desc_fifo
    import xsq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  xsq_desc_t        push_data,
    input  logic             pop,
    output xsq_desc_t        pop_data,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    xsq_desc_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign push_ok  = push && !full && !flush;
    assign pop_ok   = pop && !empty && !flush;
    assign pop_data = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/xsq_mover_stub.sv
module xsq_mover_stub
    import xsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                run,
    input  logic                avail,
    input  xsq_desc_t           desc_in,
    output logic                take,
    output logic                fin,
    output logic [XSQ_ID_W-1:0] fin_id
);

    mv_state_t             state;
    mv_state_t             state_nx;
    xsq_desc_t             cur;
    logic [XSQ_LEN_W-1:0]  icnt;
    logic [XSQ_LEN_W-1:0]  ocnt;
    logic                  last_beat;

    assign last_beat = (icnt == cur.inner) && (ocnt == cur.outer);
    assign fin_id    = cur.id;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state <= MV_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        take     = 1'b0;
        fin      = 1'b0;
        unique case (state)
            MV_IDLE: begin
                if (run && avail) begin
                    take     = 1'b1;
                    state_nx = MV_XFER;
                end
            end
            MV_XFER: begin
                if (run && last_beat) begin
                    fin      = 1'b1;
                    state_nx = cur.cyclic ? MV_XFER : MV_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            icnt <= '0;
            ocnt <= '0;
        end else if (take) begin
            cur  <= desc_in;
            icnt <= '0;
            ocnt <= '0;
        end else if (state == MV_XFER && run) begin
            if (last_beat) begin
                icnt <= '0;
                ocnt <= '0;
            end else if (icnt == cur.inner) begin
                icnt <= '0;
                ocnt <= ocnt + 1'b1;
            end else begin
                icnt <= icnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xsq_irq_ctrl.sv
module xsq_irq_ctrl #(
    parameter int CAUSES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              pend_we,
    input  logic [CAUSES-1:0] wbits,
    input  logic [CAUSES-1:0] events,
    output logic [CAUSES-1:0] mask,
    output logic [CAUSES-1:0] pend,
    output logic [CAUSES-1:0] active,
    output logic              irq
);

    logic [CAUSES-1:0] clr_bits;

    assign clr_bits = pend_we ? wbits : '0;
    assign active   = pend & ~mask;
    assign irq      = |active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
            pend <= '0;
        end else begin
            if (mask_we) begin
                mask <= wbits;
            end
            pend <= (pend & ~clr_bits) | events;
        end
    end

endmodule

// File: rtl/xfer_submit_queue.sv
module xfer_submit_queue
    import xsq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    ctl_state_t            ctl_state;
    ctl_state_t            ctl_nx;
    logic                  run;
    logic                  flush;
    logic [1:0]            ctl_view;

    logic [2:0]            flags_q;
    logic [XSQ_LEN_W-1:0]  inner_q;
    logic [XSQ_LEN_W-1:0]  outer_q;
    logic [XSQ_ID_W-1:0]   next_id;
    logic [XSQ_IDS-1:0]    done_q;
    logic [XSQ_IDS-1:0]    done_set;

    logic                  q_empty;
    logic                  q_full;
    logic [CNT_W-1:0]      q_count;
    xsq_desc_t             q_in;
    xsq_desc_t             q_out;
    logic                  accept;
    logic                  pop;
    logic                  fin;
    logic [XSQ_ID_W-1:0]   fin_id;
    logic                  eot_evt;
    logic                  rd_done;

    logic [1:0]            irq_mask;
    logic [1:0]            irq_pend;
    logic [1:0]            irq_active;

    logic                  unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:XSQ_LEN_W];

    // control state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_state <= CS_OFF;
        end else begin
            ctl_state <= ctl_nx;
        end
    end

    // control next state
    always_comb begin
        ctl_nx = ctl_state;
        if (reg_wr && reg_addr == A_CTRL) begin
            if (!reg_wdata[0]) begin
                ctl_nx = CS_OFF;
            end else if (reg_wdata[1]) begin
                ctl_nx = CS_HOLD;
            end else begin
                ctl_nx = CS_RUN;
            end
        end
    end

    // control outputs
    always_comb begin
        run      = 1'b0;
        flush    = 1'b0;
        ctl_view = 2'b00;
        unique case (ctl_state)
            CS_OFF: begin
                flush = 1'b1;
            end
            CS_RUN: begin
                run      = 1'b1;
                ctl_view = 2'b01;
            end
            CS_HOLD: begin
                ctl_view = 2'b11;
            end
            default: begin
                flush = 1'b1;
            end
        endcase
    end

    assign accept = reg_wr && reg_addr == A_START && reg_wdata[0]
                    && !flush && !q_full;
    assign rd_done = reg_rd && reg_addr == A_DONE;

    always_comb begin
        q_in        = '0;
        q_in.id     = next_id;
        q_in.cyclic = flags_q[0];
        q_in.inner  = inner_q;
        q_in.outer  = outer_q;
    end

    // descriptor staging registers and ID allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            inner_q <= '0;
            outer_q <= '0;
            next_id <= '0;
        end else begin
            if (reg_wr && reg_addr == A_FLAGS) begin
                flags_q <= reg_wdata[2:0];
            end
            if (reg_wr && reg_addr == A_INNER) begin
                inner_q <= reg_wdata[XSQ_LEN_W-1:0];
            end
            if (reg_wr && reg_addr == A_OUTER) begin
                outer_q <= reg_wdata[XSQ_LEN_W-1:0];
            end
            if (accept) begin
                next_id <= next_id + 1'b1;
            end
        end
    end

    xsq_desc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (accept),
        .push_data (q_in),
        .pop       (pop),
        .pop_data  (q_out),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count)
    );

    xsq_mover_stub u_mover (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .run     (run),
        .avail   (!q_empty),
        .desc_in (q_out),
        .take    (pop),
        .fin     (fin),
        .fin_id  (fin_id)
    );

    // completion mask: read clears what was returned, new sets survive
    assign done_set = fin ? (XSQ_IDS'(1) << fin_id) : '0;
    assign eot_evt  = fin && (!done_q[fin_id] || rd_done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else if (rd_done) begin
            done_q <= done_set;
        end else begin
            done_q <= done_q | done_set;
        end
    end

    xsq_irq_ctrl #(.CAUSES(2)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (reg_wr && reg_addr == A_IRQ_MASK),
        .pend_we (reg_wr && reg_addr == A_IRQ_PEND),
        .wbits   (reg_wdata[1:0]),
        .events  ({eot_evt, pop}),
        .mask    (irq_mask),
        .pend    (irq_pend),
        .active  (irq_active),
        .irq     (irq)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_IRQ_MASK: reg_rdata[1:0] = irq_mask;
            A_IRQ_PEND: reg_rdata[1:0] = irq_pend;
            A_IRQ_SRC:  reg_rdata[1:0] = irq_active;
            A_CTRL:     reg_rdata[1:0] = ctl_view;
            A_NEXT_ID:  reg_rdata[XSQ_ID_W-1:0] = next_id;
            A_START:    reg_rdata[0] = flush || q_full;
            A_FLAGS:    reg_rdata[2:0] = flags_q;
            A_INNER:    reg_rdata[XSQ_LEN_W-1:0] = inner_q;
            A_OUTER:    reg_rdata[XSQ_LEN_W-1:0] = outer_q;
            A_DONE:     reg_rdata[XSQ_IDS-1:0] = done_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/xsq_checker.sv
module xsq_checker
    import xsq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input ctl_state_t          ctl_state,
    input logic [CNT_W-1:0]    q_count,
    input logic                accept,
    input logic [XSQ_ID_W-1:0] next_id,
    input logic                pop,
    input logic                fin,
    input logic [XSQ_ID_W-1:0] fin_id,
    input logic [XSQ_IDS-1:0]  done_q,
    input logic [1:0]          irq_pend
);

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH)); // R2

    AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> next_id == $past(next_id) + 1'b1); // R3

    AST_DONE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_q[$past(fin_id)]); // R4

    AST_SOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> irq_pend[0]); // R6

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_state == CS_HOLD |-> !pop && !fin); // R9

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_state == CS_OFF |-> !pop && !fin && !accept); // R10

endmodule

bind xfer_submit_queue xsq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_xsq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_state (ctl_state),
    .q_count   (q_count),
    .accept    (accept),
    .next_id   (next_id),
    .pop       (pop),
    .fin       (fin),
    .fin_id    (fin_id),
    .done_q    (done_q),
    .irq_pend  (irq_pend)
);

// File: tb/xfer_submit_queue_test.sv
`timescale 1ns/1ps
module xfer_submit_queue_test;

    localparam int DEPTH = 4;

    logic        clk;
    logic        rst_n;
    logic        reg_wr;
    logic        reg_rd;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks;
    int errors;
    int cycles;
    bit finished;

    xfer_submit_queue #(.DEPTH(DEPTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
                report();
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic submit(input logic [7:0] inr, input logic [7:0] otr, input logic [2:0] fl);
        wr(12'h418, {24'd0, inr});
        wr(12'h41C, {24'd0, otr});
        wr(12'h40C, {29'd0, fl});
        wr(12'h408, 32'd1);
    endtask

    // bench model: duration of a transfer from R12
    function automatic int xfer_cycles(input logic [7:0] inr, input logic [7:0] otr);
        return (int'(inr) + 1) * (int'(otr) + 1);
    endfunction

    // poll done until all bits in want seen or limit, returns OR of reads
    task automatic poll_done(input logic [31:0] want, input int limit, output logic [31:0] seen);
        logic [31:0] v;
        seen = '0;
        for (int i = 0; i < limit; i++) begin
            rd(12'h428, v);
            seen |= v;
            if ((seen & want) == want) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] seen;
        logic [4:0]  exp_id;
        logic [7:0]  ri;
        logic [7:0]  ro;
        int          dummy;
        checks = 0; errors = 0; finished = 1'b0;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        rst_n = 1'b0;
        dummy = $urandom(32'd1234);
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(12'h400, v); check("R1 ctrl", v, 32'd0);
        rd(12'h080, v); check("R1 mask", v, 32'd3);
        rd(12'h084, v); check("R1 pending", v, 32'd0);
        rd(12'h404, v); check("R1 next id", v, 32'd0);
        rd(12'h428, v); check("R1 done", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd(12'h408, v); check("R2 start busy while disabled", v, 32'd1);

        // R12 register widths
        wr(12'h40C, 32'hFFFF_FFFF); rd(12'h40C, v); check("R12 flags readback", v, 32'd7);
        wr(12'h418, 32'h0000_1234); rd(12'h418, v); check("R12 inner readback", v, 32'h34);
        wr(12'h41C, 32'h0000_ABCD); rd(12'h41C, v); check("R12 outer readback", v, 32'hCD);

        // R10 start write ignored while disabled
        submit(8'd1, 8'd0, 3'd0);
        rd(12'h404, v); check("R10 id unchanged while disabled", v, 32'd0);

        // R9 fill queue while paused
        wr(12'h400, 32'd3);
        rd(12'h400, v); check("R9 ctrl reads pause", v, 32'd3);
        rd(12'h408, v); check("R2 start free", v, 32'd0);
        for (int k = 0; k < DEPTH; k++) submit(8'd2, 8'd0, 3'd0);
        rd(12'h408, v); check("R2 start busy when full", v, 32'd1);
        rd(12'h404, v); check("R3 id after fills", v, 32'(DEPTH));
        submit(8'd2, 8'd0, 3'd0);
        rd(12'h404, v); check("R2 submit while full ignored", v, 32'(DEPTH));
        idle(40);
        rd(12'h428, v); check("R9 nothing completes while paused", v, 32'd0);
        rd(12'h084, v); check("R9 nothing leaves queue while paused", v, 32'd0);

        // R4 run the queue
        wr(12'h400, 32'd1);
        idle(DEPTH * (xfer_cycles(8'd2, 8'd0) + 2) + 5);
        rd(12'h428, v); check("R4 done mask", v, 32'h0000_000F);
        rd(12'h428, v); check("R5 done cleared by read", v, 32'd0);
        rd(12'h084, v); check("R6 both causes pending", v, 32'd3);
        check("R8 irq masked", {31'd0, irq}, 32'd0);
        wr(12'h080, 32'd0);
        rd(12'h088, v); check("R8 source", v, 32'd3);
        check("R8 irq unmasked", {31'd0, irq}, 32'd1);
        wr(12'h084, 32'd1); rd(12'h084, v); check("R7 clear bit0", v, 32'd2);
        wr(12'h084, 32'd0); rd(12'h084, v); check("R7 write 0 no effect", v, 32'd2);
        wr(12'h080, 32'd2);
        rd(12'h088, v); check("R8 source masked bit1", v, 32'd0);
        check("R8 irq low when masked", {31'd0, irq}, 32'd0);
        wr(12'h084, 32'd2); rd(12'h084, v); check("R7 clear bit1", v, 32'd0);
        wr(12'h080, 32'd0);

        // R4 ordering: long then short
        submit(8'd7, 8'd3, 3'd0);   // id 4, 32 cycles
        submit(8'd0, 8'd0, 3'd0);   // id 5, 1 cycle
        seen = '0;
        for (int i = 0; i < 200; i++) begin
            rd(12'h428, v);
            if (v != 0) begin seen = v; break; end
        end
        check("R4 long transfer finishes first", seen & 32'h10, 32'h10);
        poll_done(32'h20, 50, v);
        check("R4 second transfer follows", v & 32'h20, 32'h20);

        // R3 / R4 random submissions across the ID wrap
        exp_id = 5'd6;
        for (int k = 0; k < 30; k++) begin
            ri = 8'($urandom % 8);
            ro = 8'($urandom % 4);
            rd(12'h404, v); check("R3 next id", v, {27'd0, exp_id});
            submit(ri, ro, 3'd0);
            poll_done(32'd1 << exp_id, xfer_cycles(ri, ro) + 10, seen);
            check("R4 random completion", seen & (32'd1 << exp_id), 32'd1 << exp_id);
            exp_id = exp_id + 5'd1;
        end
        rd(12'h404, v); check("R3 id wrapped", v, {27'd0, exp_id});

        // R11 cyclic repeat, R6 newly-set rule
        wr(12'h084, 32'd3);
        submit(8'd1, 8'd0, 3'd1);
        poll_done(32'd1 << exp_id, 20, seen);
        check("R11 first pass", seen & (32'd1 << exp_id), 32'd1 << exp_id);
        idle(10);
        rd(12'h428, v); check("R11 repeats after read", v, 32'd1 << exp_id);
        idle(3);
        wr(12'h084, 32'd2);
        idle(10);
        rd(12'h084, v); check("R6 no eot while bit already set", v & 32'd2, 32'd0);
        wr(12'h400, 32'd0);
        rd(12'h428, v);
        idle(10);
        rd(12'h428, v); check("R10 cyclic stopped on disable", v, 32'd0);
        exp_id = exp_id + 5'd1;

        // R10 flush of queued work
        wr(12'h400, 32'd3);
        submit(8'd1, 8'd0, 3'd0);
        submit(8'd1, 8'd0, 3'd0);
        wr(12'h400, 32'd0);
        wr(12'h084, 32'd3);
        wr(12'h400, 32'd1);
        idle(30);
        rd(12'h428, v); check("R10 flushed work never completes", v, 32'd0);
        rd(12'h084, v); check("R10 flushed work never dequeued", v, 32'd0);
        rd(12'h404, v); check("R3 id kept across flush", v, {27'd0, exp_id + 5'd2});

        report();
    end

endmodule